// File: doc/BRIEF.md
# Persistence-Filtered Loopback Request Detector

This block looks at loopback indicator bits that arrive from the overhead of a multiplexed DS3 signal in M13 framing. It keeps one request flag for each of 28 DS1 tributaries. An upstream framer delivers one sample per strobe. Each sample carries a tributary index, a flag that says whether the bit came from a C-bit or from a stuff-bit position, and the bit value. A bit value of 1 means "loopback requested" and 0 means "normal". For each of the seven DS2 groups, one configuration bit selects which of the two positions carries the indicator for the four tributaries in that group. Samples from the other position are discarded.

Each tributary has two filters, one in each direction, so a request changes only after a steady run of agreeing samples. A flag rises after five successive indicator samples and falls after five successive normal samples. Detection runs only while the DS2 and DS3 framers both report sync. A loss of either sync empties every run counter but leaves the flags as they are. Any number of flags may be set at once. A one-cycle pulse marks every cycle in which the flag vector changes, so that a processor can update the loopback paths.

Top module: `loopback_req_detect`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `reqFlags` is all zero and `reqChange` is 0.
- R2: For an accepted sample with bit value 1, the tributary's flag becomes 1 in the cycle after the fifth such sample in an unbroken run. After only four, it stays 0. Further samples of 1 leave it at 1.
- R3: A set flag clears in the cycle after the fifth successive accepted sample with bit value 0 for that tributary. After only four, it stays 1.
- R4: An accepted sample of the opposite value breaks a run. A new run then needs five more matching samples.
- R5: Tributary n belongs to DS2 group n/4. `sampleKind` is 0 for a C-bit and 1 for a stuff bit. A sample is accepted only if `sampleKind` equals `srcSel[n/4]`. Otherwise it has no effect.
- R6: While `ds2Sync` or `ds3Sync` is 0, no sample is accepted, every run counter empties, and every flag keeps its value. After sync returns, a run needs five fresh samples.
- R7: Tributaries filter independently. Several flags may be 1 at the same time.
- R8: `reqChange` is 1 for exactly the cycles in which `reqFlags` differs from its value in the previous cycle.
- R9: A sample with a tributary index of 28 or more is ignored.
- R10: Bit n of `reqFlags` belongs to tributary index n. Seen as four 7-bit bytes, byte k holds tributaries 7k to 7k+6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | A sample is present this cycle |
| sampleChan | input | 5 | Tributary index of the sample |
| sampleKind | input | 1 | 0 = C-bit position, 1 = stuff-bit position |
| sampleBit | input | 1 | Sampled indicator value, 1 = loopback |
| srcSel | input | 7 | Per-DS2 group indicator source, same coding as sampleKind |
| ds2Sync | input | 1 | DS2 frame sync present |
| ds3Sync | input | 1 | DS3 frame sync present |
| reqFlags | output | 28 | Per-tributary loopback request flags |
| reqChange | output | 1 | One-cycle pulse when any flag changes |

## Verification
A run counter that is one off, or that was not emptied, makes a flag change one sample early or late. This shows on `reqFlags` one cycle after the sample that should, or should not, have completed the run. A wrong source selection or a bad group decode changes the flag of an unrelated tributary, or misses a change, by that same cycle. Flags that hold wrong values across a sync loss differ from the expected vector on the very next cycle. The bench compares the whole vector and the pulse after every sample, so any such fault shows at most one cycle after the sample that caused it.

// File: rtl/lbdet_pkg.sv
package lbdet_pkg;
  localparam int NUM_DS2    = 7;
  localparam int CH_PER_DS2 = 4;
  localparam int NUM_CH     = NUM_DS2 * CH_PER_DS2;
  localparam int RUN_LEN    = 5;
  localparam int CHAN_W     = $clog2(NUM_CH);
  localparam int CNT_W      = $clog2(RUN_LEN + 1);

  // Strobes from the control part to the datapath
  typedef struct packed {
    logic              hit;    // accepted sample, indicator value
    logic              miss;   // accepted sample, normal value
    logic              flush;  // sync lost: empty all run counters
    logic [CHAN_W-1:0] chan;
  } lbStrobe_t;
endpackage

// File: rtl/lbdet_ctrl.sv
module lbdet_ctrl
  import lbdet_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleValid,
  input  logic [CHAN_W-1:0] sampleChan,
  input  logic              sampleKind,
  input  logic              sampleBit,
  input  logic [NUM_DS2-1:0] srcSel,
  input  logic              ds2Sync,
  input  logic              ds3Sync,
  output lbStrobe_t         strb
);
  localparam int DS2_W = $clog2(NUM_DS2 + 1);

  logic             inSync;
  logic             chanOk;
  logic [DS2_W-1:0] ds2Idx;
  logic             selKind;
  logic             take;

  always_comb begin
    inSync  = ds2Sync & ds3Sync;
    chanOk  = (32'(sampleChan) < NUM_CH);
    ds2Idx  = DS2_W'(32'(sampleChan) / CH_PER_DS2);
    selKind = 1'b0;
    for (int d = 0; d < NUM_DS2; d++)
      if (chanOk && (32'(ds2Idx) == d)) selKind = srcSel[d];
    take       = sampleValid & inSync & chanOk & (sampleKind == selKind);
    strb.hit   = take & sampleBit;
    strb.miss  = take & ~sampleBit;
    strb.flush = ~inSync;
    strb.chan  = sampleChan;
  end

  // R9
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.hit || strb.miss) |-> (32'(sampleChan) < NUM_CH));

  // R6
  sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds2Sync || !ds3Sync) |-> !(strb.hit || strb.miss));
endmodule

// File: rtl/lbdet_dp.sv
module lbdet_dp
  import lbdet_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  lbStrobe_t         strb,
  output logic [NUM_CH-1:0] reqFlags,
  output logic              reqChange
);
  logic [NUM_CH-1:0] flagNxt;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic [CNT_W-1:0] setCnt;
    logic [CNT_W-1:0] clrCnt;
    logic             sel;

    assign sel = (32'(strb.chan) == g);

    always_comb begin
      flagNxt[g] = reqFlags[g];
      if (!strb.flush && sel) begin
        if (strb.hit && (32'(setCnt) >= RUN_LEN - 1))
          flagNxt[g] = 1'b1;
        else if (strb.miss && (32'(clrCnt) >= RUN_LEN - 1))
          flagNxt[g] = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        setCnt <= '0;
        clrCnt <= '0;
      end else if (strb.flush) begin
        setCnt <= '0;
        clrCnt <= '0;
      end else if (sel && strb.hit) begin
        if (32'(setCnt) < RUN_LEN) setCnt <= setCnt + 1'b1;
        clrCnt <= '0;
      end else if (sel && strb.miss) begin
        if (32'(clrCnt) < RUN_LEN) clrCnt <= clrCnt + 1'b1;
        setCnt <= '0;
      end
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(setCnt) <= RUN_LEN) && (32'(clrCnt) <= RUN_LEN)
      && !((setCnt != '0) && (clrCnt != '0)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqFlags  <= '0;
      reqChange <= 1'b0;
    end else begin
      reqFlags  <= flagNxt;
      reqChange <= |(flagNxt ^ reqFlags);
    end
  end

  // R8
  change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqChange == (reqFlags != $past(reqFlags)));

  // R6
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.flush |=> $stable(reqFlags));

  // R7
  one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reqFlags ^ $past(reqFlags)));
endmodule

// File: rtl/loopback_req_detect.sv
module loopback_req_detect
  import lbdet_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sampleValid,
  input  logic [CHAN_W-1:0]  sampleChan,
  input  logic               sampleKind,
  input  logic               sampleBit,
  input  logic [NUM_DS2-1:0] srcSel,
  input  logic               ds2Sync,
  input  logic               ds3Sync,
  output logic [NUM_CH-1:0]  reqFlags,
  output logic               reqChange
);
  lbStrobe_t strb;

  lbdet_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sampleValid(sampleValid), .sampleChan(sampleChan),
    .sampleKind(sampleKind), .sampleBit(sampleBit),
    .srcSel(srcSel), .ds2Sync(ds2Sync), .ds3Sync(ds3Sync),
    .strb(strb)
  );

  lbdet_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .reqFlags(reqFlags), .reqChange(reqChange)
  );
endmodule

// File: tb/loopback_req_detect_bench.sv
module loopback_req_detect_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sampleValid = 1'b0;
  logic [4:0]  sampleChan = '0;
  logic        sampleKind = 1'b0;
  logic        sampleBit = 1'b0;
  logic [6:0]  srcSel = '0;
  logic        ds2Sync = 1'b1;
  logic        ds3Sync = 1'b1;
  logic [27:0] reqFlags;
  logic        reqChange;

  int errors = 0;
  int checks = 0;
  int setRun [28];
  int clrRun [28];
  logic [27:0] expFlags = '0;
  logic        expChange = 1'b0;

  always #10 clk = ~clk;

  loopback_req_detect u_loopback_req_detect (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid),
    .sampleChan(sampleChan), .sampleKind(sampleKind),
    .sampleBit(sampleBit), .srcSel(srcSel), .ds2Sync(ds2Sync),
    .ds3Sync(ds3Sync), .reqFlags(reqFlags), .reqChange(reqChange)
  );

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: run did not end, got hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic bit accepted(bit v, int ch, bit kind, bit s2, bit s3,
                                  logic [6:0] sel);
    if (!v || !s2 || !s3 || ch >= 28) return 0;
    return kind == sel[ch/4];
  endfunction

  task automatic modelStep(bit v, int ch, bit kind, bit b, bit s2, bit s3);
    logic [27:0] old = expFlags;
    if (!(s2 && s3)) begin
      for (int i = 0; i < 28; i++) begin setRun[i] = 0; clrRun[i] = 0; end
    end else if (accepted(v, ch, kind, s2, s3, srcSel)) begin
      if (b) begin
        clrRun[ch] = 0;
        if (setRun[ch] < 5) setRun[ch]++;
        if (setRun[ch] >= 5) expFlags[ch] = 1'b1;
      end else begin
        setRun[ch] = 0;
        if (clrRun[ch] < 5) clrRun[ch]++;
        if (clrRun[ch] >= 5) expFlags[ch] = 1'b0;
      end
    end
    expChange = (expFlags != old);
  endtask

  task automatic check(string tag);
    checks++;
    if (reqFlags !== expFlags || reqChange !== expChange) begin
      errors++;
      $display("FAIL %s: flags=%h change=%b expected flags=%h change=%b",
               tag, reqFlags, reqChange, expFlags, expChange);
    end
  endtask

  task automatic step(bit v, int ch, bit kind, bit b, bit s2, bit s3, string tag);
    @(negedge clk);
    sampleValid = v; sampleChan = 5'(ch); sampleKind = kind;
    sampleBit = b; ds2Sync = s2; ds3Sync = s3;
    modelStep(v, ch, kind, b, s2, s3);
    @(posedge clk); #1;
    check(tag);
  endtask

  task automatic run(int n, int ch, bit kind, bit b, string tag);
    for (int i = 0; i < n; i++) step(1, ch, kind, b, 1, 1, tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 28; i++) begin setRun[i] = 0; clrRun[i] = 0; end
    repeat (3) @(posedge clk);
    #1 check("R1 reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 check("R1 after reset");

    // R2: four indicator samples do not set, fifth does
    run(4, 3, 0, 1, "R2 four");
    step(1, 3, 0, 1, 1, 1, "R2 fifth R8");
    step(0, 3, 0, 0, 1, 1, "R8 pulse ends");
    run(3, 3, 0, 1, "R2 saturate");
    // R4: broken run
    run(4, 3, 0, 0, "R4 four normal");
    step(1, 3, 0, 1, 1, 1, "R4 break");
    run(4, 3, 0, 0, "R4 restart four");
    // R3: clear after five
    step(1, 3, 0, 0, 1, 1, "R3 fifth clears");
    // R5: group 2 uses stuff bits
    srcSel = 7'b0000100;
    run(5, 10, 0, 1, "R5 C-bit ignored");
    run(5, 10, 1, 1, "R5 stuff counted");
    // R6: sync loss empties counters, flags held
    run(4, 0, 0, 1, "R6 pre");
    step(1, 0, 0, 1, 1, 0, "R6 ds3 lost");
    step(1, 0, 0, 0, 0, 1, "R6 ds2 lost");
    run(4, 0, 0, 1, "R6 fresh four");
    step(1, 0, 0, 1, 1, 1, "R6 fifth");
    // R9: out-of-range index
    run(6, 30, 0, 1, "R9 ignored");
    run(6, 28, 1, 1, "R9 ignored");
    // R7 / R10: several tributaries, top bit
    run(5, 27, 0, 1, "R7 R10 bit27");
    run(5, 7, 0, 1, "R10 byte1 first");
    if (reqFlags[27] !== 1'b1 || reqFlags[7] !== 1'b1 || reqFlags[10] !== 1'b1) begin
      errors++;
      $display("FAIL R7: flags=%h expected bits 27,10,7,0 set", reqFlags);
    end
    checks++;

    // Constrained random: few channels, sticky bits for long runs
    for (int k = 0; k < 4000; k++) begin
      int ch = ($urandom % 8) * 4 + ($urandom % 2);
      bit v = ($urandom % 8) != 0;
      bit kind = ($urandom % 6) == 0 ? ~srcSel[ch % 28 / 4] : srcSel[ch % 28 / 4];
      bit b = ((k / 40) % 2) == 1 ? (($urandom % 10) != 0) : (($urandom % 10) == 0);
      bit s = ($urandom % 40) != 0;
      if (k % 500 == 0) srcSel = 7'($urandom);
      step(v, ch, kind, b, s, 1, "R2 R3 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule